// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block sits in front of the request latches of an interrupt controller and conditions a set of external interrupt pins. It brings each pin into the clock domain, then turns its activity into a one-bit request-set indication for that pin. What counts as activity depends on a per-pin trigger mode: a low level, a high level, a rising transition or a falling transition.

Each trigger mode is two bits wide, and four modes are packed into one byte. The mode bytes are written and read over a small byte bus. The set-only request latches downstream accept a pulse or a held level alike, so level modes drive the request indication on every cycle the pin is active. Edge modes drive it for exactly one cycle per qualifying transition. The block never withdraws a request that it has already signalled. Clearing and prioritising requests belong to the controller.

The pins and the bus are plain control interfaces. There is no valid/ready handshake, so neither side can apply back-pressure. A bus write completes on the clock edge at which `bus_sel` and `bus_we` are both high. Read data is combinational from the current address while `bus_sel` is high.

Top module: `irq_trigger_cond`

## Requirements
- R1: After reset every pin's mode reads as falling edge, so both mode bytes read 0xFF, and `req_o` is all zero while the pins are low.
- R2: The mode encoding is 0 = active low, 1 = active high, 2 = rising edge and 3 = falling edge. Pin n is held in the byte at offset n/4, in bits 2(n%4)+1:2(n%4). A byte written there reads back unchanged.
- R3: Reads at offsets 2 and above return zero, and writes at those offsets leave both mode bytes unchanged.
- R4: In rising-edge mode, a 0-to-1 change on a pin raises that pin's request bit after the second rising clock edge that follows the change, for exactly one cycle.
- R5: In falling-edge mode, a 1-to-0 change raises the pin's request bit with the same latency as R4, for exactly one cycle.
- R6: In active-high mode, the request bit follows the synchronised pin: high on every cycle it is 1 and low otherwise, with the latency of R4.
- R7: In active-low mode, the request bit is high on every cycle the synchronised pin is 0 and low otherwise, with the latency of R4.
- R8: Rewriting a mode while the pin is steady produces no request in an edge mode. The previous synchronised sample survives the change, so a later transition is still detected against it.
- R9: Each pin drives only its own bit of `req_o`. The request bit of every other pin is unaffected.
- R10: An edge mode ignores the opposite transition and a steady pin: no request bit is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | External interrupt pins; may be asynchronous |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the mode register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data; zero when not selected or unmapped |
| req_o | output | NUM_PINS | Per-pin request-set indication |

## Verification
The checker relates each request bit to the synchronised pin, which enters the detector, and to that pin's mode field. This relies on the synchroniser and the previous-sample register both resetting to 0, so that the first comparison after reset starts from a consistent history. It also assumes the mode fields change only through bus writes, so that writes to unmapped offsets can be checked for leaving them stable. The bench meets these assumptions: it holds reset from time zero and changes pins and bus signals only on falling clock edges. It settles each pin for three cycles before every transition it checks, so each expected value depends only on the mode and on the old and new pin levels.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/irq_trig_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
module irq_trig_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_trig_modes.sv
// Packed trigger-mode registers on a byte bus.
module irq_trig_modes
  import irq_trig_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [NUM_PINS*MODE_W-1:0] mode_o
);
  localparam int PINS_PER_REG = DATA_W / MODE_W;
  localparam int NUM_REGS     = NUM_PINS / PINS_PER_REG;

  logic [NUM_PINS*MODE_W-1:0] mode_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = bus_sel && bus_we && (bus_addr == ADDR_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mode_q[r*DATA_W +: DATA_W] <= {PINS_PER_REG{TRIG_FALL}};
      else if (hit) mode_q[r*DATA_W +: DATA_W] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (bus_sel && bus_addr == ADDR_W'(r)) bus_rdata = mode_q[r*DATA_W +: DATA_W];
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/irq_trig_detect.sv
// Per-pin edge/level qualification against the previous synchronised sample.
module irq_trig_detect
  import irq_trig_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        sync_i,
  input  logic [NUM_PINS*MODE_W-1:0] mode_i,
  output logic [NUM_PINS-1:0]        req_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    trig_mode_e mode;
    assign mode = trig_mode_e'(mode_i[p*MODE_W +: MODE_W]);
    always_comb begin
      unique case (mode)
        TRIG_LOW:  req_o[p] = ~sync_i[p];
        TRIG_HIGH: req_o[p] = sync_i[p];
        TRIG_RISE: req_o[p] = sync_i[p] & ~prev_q[p];
        default:   req_o[p] = ~sync_i[p] & prev_q[p];
      endcase
    end
  end
endmodule

// File: rtl/irq_trigger_cond.sv
module irq_trigger_cond
  import irq_trig_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] req_o
);
  logic [NUM_PINS-1:0]        pin_sync;
  logic [NUM_PINS*MODE_W-1:0] mode_vec;

  irq_trig_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_sync)
  );

  irq_trig_modes #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_modes (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_o(mode_vec)
  );

  irq_trig_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_i(pin_sync), .mode_i(mode_vec), .req_o(req_o)
  );
endmodule

// File: rtl/irq_trigger_cond_chk.sv
module irq_trigger_cond_chk
  import irq_trig_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_sel,
  input logic                       bus_we,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [NUM_PINS-1:0]        sync_i,
  input logic [NUM_PINS*MODE_W-1:0] mode_i,
  input logic [NUM_PINS-1:0]        req_o
);
  localparam int NUM_REGS = NUM_PINS / (DATA_W / MODE_W);

  logic out_of_reset_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_of_reset_q <= 1'b0;
    else        out_of_reset_q <= 1'b1;
  end

  // R1: modes hold the falling-edge value at the first edge after reset
  always_ff @(posedge clk) begin
    if (rst_n && !out_of_reset_q)
      a_r1_reset_modes: assert (&mode_i);
  end

  // R3: writes to unmapped offsets leave the modes untouched
  a_r3_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && (int'(bus_addr) >= NUM_REGS)) |=> $stable(mode_i));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    logic [MODE_W-1:0] m;
    assign m = mode_i[p*MODE_W +: MODE_W];

    a_r4_rise_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (m == TRIG_RISE && req_o[p]) |-> (sync_i[p] && !$past(sync_i[p])));

    a_r5_fall_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (m == TRIG_FALL && req_o[p]) |-> (!sync_i[p] && $past(sync_i[p])));

    a_r6_high_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (m == TRIG_HIGH) |-> (req_o[p] == sync_i[p]));

    a_r7_low_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (m == TRIG_LOW) |-> (req_o[p] == !sync_i[p]));
  end
endmodule

bind irq_trigger_cond irq_trigger_cond_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .sync_i(pin_sync), .mode_i(mode_vec), .req_o(req_o)
);

// File: tb/test_irq_trigger_cond.sv
`timescale 1ns/1ps
module test_irq_trigger_cond;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_trigger_cond i_irq_trigger_cond (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_o(req_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic exp_req(input int mode, input logic prv, input logic cur);
    case (mode)
      0: return !cur;
      1: return cur;
      2: return cur && !prv;
      default: return !cur && prv;
    endcase
  endfunction

  function automatic string tag_of(input int mode, input logic o, input logic n);
    case (mode)
      0: return "R7";
      1: return "R6";
      2: return (!o && n) ? "R4" : "R10";
      default: return (o && !n) ? "R5" : "R10";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] byte_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(1);

    // R1: reset modes and idle requests
    bus_read(4'd0, rd); chk("R1 mode byte 0", rd, 8'hFF);
    bus_read(4'd1, rd); chk("R1 mode byte 1", rd, 8'hFF);
    chk("R1 idle request", req_o, 8'h00);

    // R2: readback and field placement
    bus_write(4'd0, 8'h1B);
    bus_write(4'd1, 8'hE4);
    bus_read(4'd0, rd); chk("R2 readback byte 0", rd, 8'h1B);
    bus_read(4'd1, rd); chk("R2 readback byte 1", rd, 8'hE4);

    // R3: unmapped offsets
    for (int a = 2; a < 16; a++) begin
      bus_write(4'(a), 8'h00);
      bus_read(4'(a), rd); chk($sformatf("R3 read offset %0d", a), rd, 8'h00);
    end
    bus_read(4'd0, rd); chk("R3 byte 0 kept", rd, 8'h1B);
    bus_read(4'd1, rd); chk("R3 byte 1 kept", rd, 8'hE4);

    // Sweep: every pin, every mode, every transition (R2, R4-R7, R9, R10)
    bus_write(4'd0, 8'hAA);
    bus_write(4'd1, 8'hAA);
    pin_i = '0;
    tick(3);
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int t = 0; t < 4; t++) begin
          logic o, n;
          o = logic'(t[1]); n = logic'(t[0]);
          byte_v = (8'hAA & ~(8'h03 << (2 * (p % 4)))) | (8'(m) << (2 * (p % 4)));
          bus_write(4'(p / 4), byte_v);
          bus_write(4'(1 - p / 4), 8'hAA);
          pin_i[p] = o;
          tick(3);
          chk($sformatf("%s/R9 steady pin%0d mode%0d lvl%0d", tag_of(m, o, o), p, m, o),
              req_o, 8'(exp_req(m, o, o)) << p);
          pin_i[p] = n;
          tick(2);
          chk($sformatf("%s/R9 change pin%0d mode%0d %0d->%0d", tag_of(m, o, n), p, m, o, n),
              req_o, 8'(exp_req(m, o, n)) << p);
          tick(1);
          chk($sformatf("%s/R9 after pin%0d mode%0d %0d->%0d", tag_of(m, n, n), p, m, o, n),
              req_o, 8'(exp_req(m, n, n)) << p);
        end
      end
      pin_i[p] = 1'b0;
      bus_write(4'(p / 4), 8'hAA);
      tick(3);
    end

    // R8: mode change keeps edge history and makes no request
    bus_write(4'd1, 8'hA6);            // pin 5 active high
    pin_i[5] = 1'b1;
    tick(3);
    chk("R8 setup level request", req_o, 8'h20);
    bus_write(4'd1, 8'hAE);            // pin 5 falling edge, pin steady high
    for (int i = 0; i < 3; i++) begin
      chk("R8 no request on mode change", req_o, 8'h00);
      tick(1);
    end
    bus_write(4'd1, 8'hAA);            // rising edge, pin still steady high
    chk("R8 no request rise after fall", req_o, 8'h00);
    bus_write(4'd1, 8'hAE);
    pin_i[5] = 1'b0;
    tick(2);
    chk("R8 edge after mode change", req_o, 8'h20);
    tick(1);
    chk("R8 edge pulse one cycle", req_o, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule